// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects interrupt requests from five sources (two external pins, two timer overflow events and one serial-port source), gates them with per-source enable bits and a master enable, sorts them into two priority levels and presents one winning request to the CPU as a vector index. The CPU takes the request with an acknowledge strobe and ends the handler with a return strobe. The controller keeps an in-service bit per priority level, so a high-priority request may interrupt a low-priority handler but nothing interrupts a handler of equal or higher level.

Each external pin can be set up as level-sensitive (request while the pin is low) or edge-sensitive (a falling edge is latched and held until that source is acknowledged). Timer overflow pulses are latched the same way. The serial request follows its two flags directly and is never cleared by the controller; software owns those flags.

Top module: `vic_ctrl`

## Requirements
- R1: After reset the enable, priority and trigger-type settings are all zero, both in-service bits are clear, and `irq_o` is 0.
- R2: A write to the enable setting stores `wdata_i[7]` as master enable and `wdata_i[4:0]` as source enables; while the master enable is 0 no request is presented, whatever the source enables hold.
- R3: Source indices are 0 external pin 0, 1 timer 0, 2 external pin 1, 3 timer 1, 4 serial; enable and priority bit i belong to source i, and `vec_o` carries the index of the presented source.
- R4: Among pending requests at the same level the lowest source index wins; a high-level request (priority bit 1) wins over any low-level one (priority bit 0).
- R5: A high-level request is presented while only the low level is in service; no request is presented while the high level is in service, and low-level requests wait until no level is in service.
- R6: `ack_i` while `irq_o` is 1 sets the in-service bit of the presented level on the next clock (`insvc_o[1]` high, `insvc_o[0]` low); `ack_i` while `irq_o` is 0 changes nothing.
- R7: `reti_i` clears `insvc_o[1]` if it is set, otherwise `insvc_o[0]`, on the next clock.
- R8: Trigger-type bit p (`wdata_i[p]` of a type write, p = external pin number) equal to 0 selects level mode: the pin is sampled each clock and requests while the latest sample is 0; nothing is latched.
- R9: Type bit 1 selects edge mode: a sample of 1 followed by a sample of 0 latches a request one clock later; it stays latched whatever the pin does afterwards until that source is acknowledged.
- R10: A timer overflow pulse latches that timer's request on the next clock; acknowledging that timer clears it.
- R11: The serial request is the OR of the transmit and receive flag inputs, seen in the same cycle, and acknowledging it does not clear it.
- R12: When a new event (falling edge or overflow pulse) falls in the same clock as the acknowledge of that source, the request stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin_i | input | 2 | Raw external pin levels |
| tmr_ovf_i | input | 2 | Timer overflow pulses |
| ser_tx_i | input | 1 | Serial transmit flag |
| ser_rx_i | input | 1 | Serial receive flag |
| en_we_i | input | 1 | Write strobe for the enable setting |
| prio_we_i | input | 1 | Write strobe for the priority setting |
| mode_we_i | input | 1 | Write strobe for the trigger-type setting |
| wdata_i | input | 8 | Write data for the setting strobes |
| ack_i | input | 1 | CPU acknowledge of the presented request |
| reti_i | input | 1 | Return-from-handler strobe |
| irq_o | output | 1 | A request is presented |
| vec_o | output | 3 | Index of the presented source |
| lvl_hi_o | output | 1 | Presented request is high level |
| insvc_o | output | 2 | In-service bits, [1] high, [0] low |

## Verification
The acknowledge that clears a latched edge or overflow request can land in the same clock as a fresh event on that very source, and a return strobe can coincide with an acknowledge that re-arms a level. Directed sequences place a falling edge and an overflow pulse exactly on the acknowledge clock and then return, expecting the request to reappear; a random phase with frequent acknowledges, returns, pin toggles and pulses compares every cycle against a cycle-level model of the requirements.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NSRC  = 5;
    localparam int NEXT  = 2;
    localparam int NTMR  = 2;
    localparam int NLVL  = 2;
    localparam int VEC_W = $clog2(NSRC);
    localparam int DW    = 8;
    localparam int GLOB_BIT = DW - 1;
    localparam int SER_IDX  = NSRC - 1;

    typedef struct packed {
        logic            glob;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] prio;
        logic [NEXT-1:0] mode;
        logic [NTMR-1:0] tflag;
        logic [NLVL-1:0] insvc;
    } ctl_t;

    typedef struct packed {
        logic samp;
        logic prev;
        logic flag;
    } ext_t;
endpackage

// File: rtl/vic_ext_trig.sv
module vic_ext_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic edge_mode_i,
    input  logic clr_i,
    output logic req_o
);
    import vic_pkg::*;

    ext_t st_d, st_q;
    logic fall;

    always_comb begin
        st_d      = st_q;
        fall      = st_q.prev & ~st_q.samp;
        st_d.samp = pin_i;
        st_d.prev = st_q.samp;
        if (!edge_mode_i)  st_d.flag = 1'b0;
        else if (fall)     st_d.flag = 1'b1;
        else if (clr_i)    st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{samp: 1'b1, prev: 1'b1, flag: 1'b0};
        else        st_q <= st_d;
    end

    assign req_o = edge_mode_i ? st_q.flag : ~st_q.samp;
endmodule

// File: rtl/vic_pick.sv
module vic_pick #(
    parameter int N = vic_pkg::NSRC,
    parameter int W = vic_pkg::VEC_W
) (
    input  logic [N-1:0] req_i,
    output logic         any_o,
    output logic [W-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = W'(i);
        end
    end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
(
    input  logic [NSRC-1:0]  pend_i,
    input  logic [NSRC-1:0]  prio_i,
    input  logic [NLVL-1:0]  insvc_i,
    output logic             valid_o,
    output logic [VEC_W-1:0] idx_o,
    output logic             hi_o
);
    logic             hi_any, lo_any;
    logic [VEC_W-1:0] hi_idx, lo_idx;

    vic_pick #(.N(NSRC), .W(VEC_W)) u_hi (
        .req_i(pend_i & prio_i), .any_o(hi_any), .idx_o(hi_idx));
    vic_pick #(.N(NSRC), .W(VEC_W)) u_lo (
        .req_i(pend_i & ~prio_i), .any_o(lo_any), .idx_o(lo_idx));

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        hi_o    = 1'b0;
        if (hi_any && !insvc_i[1]) begin
            valid_o = 1'b1;
            idx_o   = hi_idx;
            hi_o    = 1'b1;
        end else if (lo_any && insvc_i == '0) begin
            valid_o = 1'b1;
            idx_o   = lo_idx;
        end
    end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NEXT-1:0]  ext_pin_i,
    input  logic [NTMR-1:0]  tmr_ovf_i,
    input  logic             ser_tx_i,
    input  logic             ser_rx_i,
    input  logic             en_we_i,
    input  logic             prio_we_i,
    input  logic             mode_we_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic             ack_i,
    input  logic             reti_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             lvl_hi_o,
    output logic [NLVL-1:0]  insvc_o
);
    ctl_t st_d, st_q;

    logic [NSRC-1:0] raw_req;
    logic [NSRC-1:0] pend;
    logic            take;

    assign take = ack_i & irq_o;

    // external pins at even indices, timers at the odd index above each
    for (genvar p = 0; p < NEXT; p++) begin : g_ext
        localparam logic [VEC_W-1:0] EIDX = VEC_W'(2 * p);
        vic_ext_trig u_trig (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (ext_pin_i[p]),
            .edge_mode_i(st_q.mode[p]),
            .clr_i      (take && vec_o == EIDX),
            .req_o      (raw_req[2*p])
        );
    end

    for (genvar t = 0; t < NTMR; t++) begin : g_tmr
        assign raw_req[2*t+1] = st_q.tflag[t];
    end

    assign raw_req[SER_IDX] = ser_tx_i | ser_rx_i;
    assign pend = raw_req & st_q.en & {NSRC{st_q.glob}};

    vic_arbiter u_arb (
        .pend_i (pend),
        .prio_i (st_q.prio),
        .insvc_i(st_q.insvc),
        .valid_o(irq_o),
        .idx_o  (vec_o),
        .hi_o   (lvl_hi_o)
    );

    always_comb begin
        st_d = st_q;
        if (en_we_i) begin
            st_d.glob = wdata_i[GLOB_BIT];
            st_d.en   = wdata_i[NSRC-1:0];
        end
        if (prio_we_i) st_d.prio = wdata_i[NSRC-1:0];
        if (mode_we_i) st_d.mode = wdata_i[NEXT-1:0];

        for (int t = 0; t < NTMR; t++) begin
            if (tmr_ovf_i[t])
                st_d.tflag[t] = 1'b1;
            else if (take && vec_o == VEC_W'(2 * t + 1))
                st_d.tflag[t] = 1'b0;
        end

        if (reti_i) begin
            if (st_q.insvc[1]) st_d.insvc[1] = 1'b0;
            else               st_d.insvc[0] = 1'b0;
        end
        if (take) begin
            if (lvl_hi_o) st_d.insvc[1] = 1'b1;
            else          st_d.insvc[0] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign insvc_o = st_q.insvc;
endmodule

// File: rtl/vic_chk.sv
module vic_chk
    import vic_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             glob_i,
    input logic             irq_i,
    input logic [VEC_W-1:0] vec_i,
    input logic             lvl_i,
    input logic [NLVL-1:0]  insvc_i,
    input logic             ack_i,
    input logic             reti_i
);
    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_i |-> !irq_i); // R2
    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |-> (vec_i < VEC_W'(NSRC))); // R3
    AST_HIGH_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        insvc_i[1] |-> !irq_i); // R5
    AST_LOW_ONLY_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (insvc_i[0] && irq_i) |-> lvl_i); // R5
    AST_ACK_MARKS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_i && lvl_i) |=> insvc_i[1]); // R6
    AST_ACK_MARKS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_i && !lvl_i) |=> insvc_i[0]); // R6
    AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_i && !reti_i) |=> insvc_i == $past(insvc_i)); // R6
    AST_RETI_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && insvc_i[1] && !(ack_i && irq_i)) |=> (!insvc_i[1] && insvc_i[0] == $past(insvc_i[0]))); // R7
endmodule

bind vic_ctrl vic_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .glob_i (st_q.glob),
    .irq_i  (irq_o),
    .vec_i  (vec_o),
    .lvl_i  (lvl_hi_o),
    .insvc_i(insvc_o),
    .ack_i  (ack_i),
    .reti_i (reti_i)
);

// File: tb/vic_ctrl_tb.sv
module vic_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext_pin = 2'b11;
    logic [1:0] tmr_ovf = 2'b00;
    logic       ser_tx = 1'b0, ser_rx = 1'b0;
    logic       en_we = 1'b0, prio_we = 1'b0, mode_we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       ack = 1'b0, reti = 1'b0;
    logic       irq_o, lvl_hi_o;
    logic [2:0] vec_o;
    logic [1:0] insvc_o;

    int    checks = 0, bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // requirement-level model
    logic       m_glob;
    logic [4:0] m_en, m_prio;
    logic [1:0] m_mode, m_samp, m_prev, m_eflag, m_tf, m_insvc;

    always #4 clk = ~clk;

    vic_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .tmr_ovf_i(tmr_ovf),
        .ser_tx_i(ser_tx), .ser_rx_i(ser_rx), .en_we_i(en_we), .prio_we_i(prio_we),
        .mode_we_i(mode_we), .wdata_i(wdata), .ack_i(ack), .reti_i(reti),
        .irq_o(irq_o), .vec_o(vec_o), .lvl_hi_o(lvl_hi_o), .insvc_o(insvc_o));

    function automatic void model_arb(output logic v, output logic [2:0] ix, output logic hi);
        logic [4:0] req, pend, hreq, lreq;
        req[0] = m_mode[0] ? m_eflag[0] : ~m_samp[0];
        req[2] = m_mode[1] ? m_eflag[1] : ~m_samp[1];
        req[1] = m_tf[0];
        req[3] = m_tf[1];
        req[4] = ser_tx | ser_rx;
        pend = m_glob ? (req & m_en) : 5'b0;
        hreq = pend & m_prio;
        lreq = pend & ~m_prio;
        v = 1'b0; ix = 3'd0; hi = 1'b0;
        if (hreq != 0 && !m_insvc[1]) begin
            v = 1'b1; hi = 1'b1;
            for (int i = 4; i >= 0; i--) if (hreq[i]) ix = 3'(i);
        end else if (lreq != 0 && m_insvc == 2'b00) begin
            v = 1'b1;
            for (int i = 4; i >= 0; i--) if (lreq[i]) ix = 3'(i);
        end
    endfunction

    always @(posedge clk) begin
        logic v, hi, tk;
        logic [2:0] ix;
        if (!rst_n) begin
            m_glob = 0; m_en = 0; m_prio = 0; m_mode = 0;
            m_samp = 2'b11; m_prev = 2'b11; m_eflag = 0; m_tf = 0; m_insvc = 0;
        end else begin
            model_arb(v, ix, hi);
            tk = ack & v;
            for (int p = 0; p < 2; p++) begin
                if (!m_mode[p]) m_eflag[p] = 1'b0;
                else if (m_prev[p] & ~m_samp[p]) m_eflag[p] = 1'b1;
                else if (tk && ix == 3'(2 * p)) m_eflag[p] = 1'b0;
                if (tmr_ovf[p]) m_tf[p] = 1'b1;
                else if (tk && ix == 3'(2 * p + 1)) m_tf[p] = 1'b0;
            end
            m_prev = m_samp;
            m_samp = ext_pin;
            if (reti) begin
                if (m_insvc[1]) m_insvc[1] = 1'b0;
                else m_insvc[0] = 1'b0;
            end
            if (tk) m_insvc[hi ? 1 : 0] = 1'b1;
            if (en_we) begin m_glob = wdata[7]; m_en = wdata[4:0]; end
            if (prio_we) m_prio = wdata[4:0];
            if (mode_we) m_mode = wdata[1:0];
        end
    end

    task automatic chk();
        logic v, hi;
        logic [2:0] ix;
        model_arb(v, ix, hi);
        checks++;
        if (irq_o !== v || insvc_o !== m_insvc || (v && (vec_o !== ix || lvl_hi_o !== hi))) begin
            bad++;
            $display("FAIL %s: irq/vec/hi/insvc actual=%b/%0d/%b/%b expected=%b/%0d/%b/%b",
                     cur_req, irq_o, vec_o, lvl_hi_o, insvc_o, v, ix, hi, m_insvc);
        end
    endtask

    task automatic ex(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk();
        end
    endtask

    task automatic wr(int which, logic [7:0] d);
        wdata = d;
        en_we = (which == 0); prio_we = (which == 1); mode_we = (which == 2);
        cyc();
        en_we = 0; prio_we = 0; mode_we = 0;
    endtask

    task automatic pulse_ack(); ack = 1; cyc(); ack = 0; endtask
    task automatic pulse_reti(); reti = 1; cyc(); reti = 0; endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R1: watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd7341);
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc();
        // R1 reset state
        ex("R1", {6'd0, insvc_o}, 8'h00);
        ex("R1", {7'd0, irq_o}, 8'h00);

        // R2 master enable off masks everything
        cur_req = "R2";
        wr(0, 8'h1F);
        ser_tx = 1; cyc(2);
        ex("R2", {7'd0, irq_o}, 8'h00);
        wr(0, 8'h9F);
        ex("R2", {4'd0, irq_o, vec_o}, 8'h0C);

        // R11 serial is not cleared by acknowledge
        cur_req = "R11";
        pulse_ack();
        ex("R11", {6'd0, insvc_o}, 8'h01);
        pulse_reti();
        ex("R11", {4'd0, irq_o, vec_o}, 8'h0C);
        ser_tx = 0; ser_rx = 1; cyc();
        ex("R11", {4'd0, irq_o, vec_o}, 8'h0C);
        ser_rx = 0; cyc();

        // R10 timer latch, clear, and R12 coincidence with acknowledge
        cur_req = "R10";
        tmr_ovf = 2'b01; cyc(); tmr_ovf = 0; cyc(2);
        ex("R10", {4'd0, irq_o, vec_o}, 8'h09);
        cur_req = "R12";
        tmr_ovf = 2'b01; ack = 1; cyc(); ack = 0; tmr_ovf = 0;
        pulse_reti();
        ex("R12", {4'd0, irq_o, vec_o}, 8'h09);
        cur_req = "R10";
        pulse_ack(); pulse_reti();
        ex("R10", {7'd0, irq_o}, 8'h00);

        // R8 level mode
        cur_req = "R8";
        ext_pin[0] = 0; cyc(2);
        ex("R8", {4'd0, irq_o, vec_o}, 8'h08);
        ext_pin[0] = 1; cyc(2);
        ex("R8", {7'd0, irq_o}, 8'h00);

        // R9 edge mode latches
        cur_req = "R9";
        wr(2, 8'h03);
        ext_pin[1] = 0; cyc(3);
        ex("R9", {4'd0, irq_o, vec_o}, 8'h0A);
        ext_pin[1] = 1; cyc(3);
        ex("R9", {4'd0, irq_o, vec_o}, 8'h0A);
        // R12 edge on acknowledge clock
        cur_req = "R12";
        ext_pin[1] = 0; cyc();
        pulse_ack();
        pulse_reti(); cyc();
        ex("R12", {4'd0, irq_o, vec_o}, 8'h0A);
        pulse_ack(); pulse_reti(); ext_pin[1] = 1; cyc(2);
        ex("R9", {7'd0, irq_o}, 8'h00);

        // R4 fixed order at one level
        cur_req = "R4";
        wr(2, 8'h02);
        ext_pin[0] = 0; tmr_ovf = 2'b10; ser_tx = 1; cyc(); tmr_ovf = 0; cyc(2);
        ex("R4", {4'd0, irq_o, vec_o}, 8'h08);

        // R5 preemption and R7 return order
        cur_req = "R5";
        wr(1, 8'h10);
        ex("R5", {3'd0, irq_o, lvl_hi_o, vec_o}, 8'h1C);
        ext_pin[0] = 1; ser_tx = 0;
        wr(1, 8'h00); cyc(2);
        pulse_ack();
        ex("R5", {6'd0, insvc_o}, 8'h01);
        ser_tx = 1; wr(1, 8'h10);
        ex("R5", {3'd0, irq_o, lvl_hi_o, vec_o}, 8'h1C);
        pulse_ack();
        ex("R5", {5'd0, irq_o, insvc_o}, 8'h03);
        ser_tx = 0;
        cur_req = "R7";
        pulse_reti();
        ex("R7", {6'd0, insvc_o}, 8'h01);
        pulse_reti();
        ex("R7", {6'd0, insvc_o}, 8'h00);

        // random phase, model compared every cycle
        cur_req = "R4";
        for (int n = 0; n < 4000; n++) begin
            ext_pin = 2'($urandom_range(0, 3));
            tmr_ovf = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            ser_tx = ($urandom_range(0, 9) == 0);
            ser_rx = ($urandom_range(0, 11) == 0);
            ack = irq_o ? ($urandom_range(0, 2) == 0) : ($urandom_range(0, 15) == 0);
            reti = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 40) == 0) begin
                wdata = 8'($urandom_range(0, 255));
                case ($urandom_range(0, 2))
                    0: begin en_we = 1; wdata[7] = ($urandom_range(0, 4) != 0); end
                    1: prio_we = 1;
                    default: mode_we = 1;
                endcase
            end
            cyc();
            en_we = 0; prio_we = 0; mode_we = 0;
        end
        ack = 0; reti = 0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule